// File: doc/BRIEF.md
# Serial CRC-16 Record Check Unit

This block protects one disk data record with a 16-bit cyclic check code, handling one bit per valid strobe. A record starts with a preset strobe, which fills the check register with ones and latches the direction (write or read). The following strobes carry the record body most-significant bit first: the one-byte address mark, then every byte of the data field. The block counts these bits itself. The record length is set by parameters.

In write mode, once the body has been absorbed, the feedback path is switched off. The next sixteen strobes then shift the register out as the two check bytes, high byte first, on `ser_o`. `ser_o` always shows the register's top bit, so the host samples it before each strobe. In read mode, the sixteen received check bits are absorbed exactly like body bits. After the last one, `err_o` reports whether the residue is non-zero. `err_o` holds its value until the next preset.

Top module: `crc16_rec_edc`

## Requirements
- R1: Reset and every preset strobe set all 16 register bits to one. They also clear the bit count, clear `err_o`, and latch `wr_mode_i` (1 = write, 0 = read) for the record. Right after a preset, `ser_o` reads 1.
- R2: Each absorbed bit forms feedback = bit XOR C15. On the shift, C0 takes the feedback, C5 takes C4 XOR feedback, C12 takes C11 XOR feedback, and every other position takes its lower neighbour. This is generator x^16 + x^12 + x^5 + 1.
- R3: The first (MARK_BYTES+FIELD_BYTES)*8 strobes after a preset are absorbed as body bits, sent most-significant bit first per byte. The default is 129 bytes.
- R4: In write mode, the 16 strobes after the body shift the register with feedback inhibited, so a zero enters C0. `bit_i` is ignored during these strobes. `ser_o` = C15, sampled before each strobe, gives the check value high bit first.
- R5: In read mode, the 16 strobes after the body are absorbed as data. From the cycle after the last one, `err_o` is 1 exactly when the register is not all zero.
- R6: After the 16 check strobes, further strobes are ignored. `err_o` and the register hold until the next preset.
- R7: A preset in the same cycle as a valid strobe wins, and that strobe is not counted or absorbed.
- R8: Cycles with `bit_vld_i` low change nothing, whatever `bit_i` carries.
- R9: In write mode `err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_i | input | 1 | Start of record: preset register, clear count, latch mode |
| wr_mode_i | input | 1 | Direction sampled at preset: 1 write, 0 read |
| bit_vld_i | input | 1 | Strobe: `bit_i` is valid this cycle |
| bit_i | input | 1 | Serial record bit, most-significant first |
| ser_o | output | 1 | Register top bit C15; the check bits in write mode |
| err_o | output | 1 | Read-mode residue non-zero after the last check bit |

## Verification
Write records with random fields are compared against a bench bit model of the generator. This separates a wrong tap position or wrong preset from a correct one, and random `bit_i` during emission shows whether the feedback is truly inhibited. Read records are sent three ways: with the correct check bytes, with one flipped check bit, and with one flipped body bit. These tell the residue test apart from an off-by-one in the bit count. Further cases cover a zero-filled short field with the deleted-data mark, back-to-back strobes against long idle gaps with noise on `bit_i`, a preset that coincides with a strobe, and an aborted record followed by a clean one.

// File: rtl/edc_pkg.sv
package edc_pkg;
    localparam int unsigned CRC_W    = 16;
    localparam logic [15:0] GEN_POLY = 16'h1021;   // x^16 + x^12 + x^5 + 1

    typedef enum logic [1:0] {
        PH_BODY  = 2'd0,
        PH_CHECK = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;
endpackage

// File: rtl/edc_shift.sv
module edc_shift #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         inhibit_i,
    input  logic         din_i,
    output logic [W-1:0] crc_o
);
    typedef struct packed {
        logic [W-1:0] crc;
    } shift_st;

    shift_st      st_d, st_q;
    logic [W-1:0] shifted;
    logic         fb;

    assign fb = (din_i ^ st_q.crc[W-1]) & ~inhibit_i;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_in
            assign shifted[i] = fb;
        end else if (POLY[i]) begin : g_xor
            assign shifted[i] = st_q.crc[i-1] ^ fb;
        end else begin : g_pass
            assign shifted[i] = st_q.crc[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.crc = '1;
        end else if (step_i) begin
            st_d.crc = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o = st_q.crc;

    // R1
    preset_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (crc_o == '1));
    // R4
    plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && inhibit_i) |=> (crc_o == {$past(crc_o[W-2:0]), 1'b0}));
    // R2
    feedback_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !inhibit_i) |=> (crc_o[0] == ($past(din_i) ^ $past(crc_o[W-1]))));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(crc_o));
endmodule

// File: rtl/edc_seq.sv
module edc_seq
    import edc_pkg::*;
#(
    parameter int unsigned BODY_BITS = 1032,
    parameter int unsigned CHK_BITS  = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   preset_i,
    input  logic   wr_mode_i,
    input  logic   bit_vld_i,
    output phase_e phase_o,
    output logic   wr_o,
    output logic   take_o,
    output logic   inhibit_o
);
    localparam int unsigned MAX_LEN = (BODY_BITS > CHK_BITS) ? BODY_BITS : CHK_BITS;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(BODY_BITS - 1);
    localparam logic [CNT_W-1:0] CHK_LAST  = CNT_W'(CHK_BITS - 1);

    typedef struct packed {
        phase_e           phase;
        logic             wr;
        logic [CNT_W-1:0] cnt;
    } seq_st;

    seq_st            st_d, st_q;
    logic             take;
    logic [CNT_W-1:0] last_idx;

    assign take     = bit_vld_i && !preset_i && (st_q.phase != PH_DONE);
    assign last_idx = (st_q.phase == PH_BODY) ? BODY_LAST : CHK_LAST;

    always_comb begin
        st_d = st_q;
        if (preset_i) begin
            st_d.phase = PH_BODY;
            st_d.wr    = wr_mode_i;
            st_d.cnt   = '0;
        end else if (take) begin
            if (st_q.cnt == last_idx) begin
                st_d.cnt   = '0;
                st_d.phase = (st_q.phase == PH_BODY) ? PH_CHECK : PH_DONE;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_BODY;
            st_q.wr    <= 1'b0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign wr_o      = st_q.wr;
    assign take_o    = take;
    assign inhibit_o = st_q.wr && (st_q.phase == PH_CHECK);

    // R7
    preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (st_q.cnt == '0 && st_q.phase == PH_BODY && st_q.wr == $past(wr_mode_i)));
    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DONE && !preset_i) |=> (st_q.phase == PH_DONE && $stable(st_q.wr)));
    // R3
    body_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BODY) |-> (st_q.cnt <= BODY_LAST));
    // R4
    check_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CHECK) |-> (st_q.cnt <= CHK_LAST));
    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld_i && !preset_i) |=> $stable(st_q));
endmodule

// File: rtl/edc_resid.sv
module edc_resid
    import edc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       phase_i,
    input  logic         wr_i,
    input  logic [W-1:0] crc_i,
    output logic         err_o
);
    logic residue_nz;

    assign residue_nz = |crc_i;
    assign err_o      = (phase_i == PH_DONE) && !wr_i && residue_nz;

    // R9
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !err_o);
    // R5
    early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != PH_DONE) |-> !err_o);
endmodule

// File: rtl/crc16_rec_edc.sv
module crc16_rec_edc
    import edc_pkg::*;
#(
    parameter int unsigned MARK_BYTES  = 1,
    parameter int unsigned FIELD_BYTES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset_i,
    input  logic wr_mode_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic ser_o,
    output logic err_o
);
    localparam int unsigned BODY_BITS = (MARK_BYTES + FIELD_BYTES) * 8;

    phase_e           phase;
    logic             wr_mode;
    logic             take;
    logic             inhibit;
    logic [CRC_W-1:0] crc;

    edc_seq #(
        .BODY_BITS (BODY_BITS),
        .CHK_BITS  (CRC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_i  (preset_i),
        .wr_mode_i (wr_mode_i),
        .bit_vld_i (bit_vld_i),
        .phase_o   (phase),
        .wr_o      (wr_mode),
        .take_o    (take),
        .inhibit_o (inhibit)
    );

    edc_shift #(
        .W    (CRC_W),
        .POLY (GEN_POLY)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (preset_i),
        .step_i    (take),
        .inhibit_i (inhibit),
        .din_i     (bit_i),
        .crc_o     (crc)
    );

    edc_resid #(
        .W (CRC_W)
    ) u_resid (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .wr_i    (wr_mode),
        .crc_i   (crc),
        .err_o   (err_o)
    );

    assign ser_o = crc[CRC_W-1];

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !preset_i) |=> err_o);
    // R1
    preset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (!err_o && ser_o));
    // R6
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !preset_i) |=> $stable(crc));
endmodule

// File: tb/crc16_rec_edc_test.sv
module crc16_rec_edc_test;
    localparam int NB = 129;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic preset_i = 1'b0;
    logic wr_mode_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic bit_i = 1'b0;
    logic ser_o, err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int max_idle = 1;
    logic [7:0] rec [NB];

    crc16_rec_edc uut (
        .clk(clk), .rst_n(rst_n), .preset_i(preset_i), .wr_mode_i(wr_mode_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .ser_o(ser_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic f;
        f = b ^ c[15];
        return {c[14:0], f} ^ (f ? 16'h1020 : 16'h0000);
    endfunction

    function automatic logic [15:0] rec_crc();
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < NB; i++)
            for (int k = 7; k >= 0; k--) c = crc_bit(c, rec[i][k]);
        return c;
    endfunction

    task automatic idle_gap();
        int n = (max_idle == 0) ? 0 : int'($urandom_range(max_idle, 0));
        for (int k = 0; k < n; k++) begin
            bit_vld_i = 1'b0;
            bit_i = 1'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic send_bit(input logic b);
        idle_gap();
        bit_vld_i = 1'b1;
        bit_i = b;
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    task automatic do_preset(input logic wr, input logic with_strobe);
        preset_i = 1'b1;
        wr_mode_i = wr;
        bit_vld_i = with_strobe;
        bit_i = 1'b1;
        @(negedge clk);
        preset_i = 1'b0;
        bit_vld_i = 1'b0;
    endtask

    task automatic send_body();
        for (int i = 0; i < NB; i++)
            for (int k = 7; k >= 0; k--) send_bit(rec[i][k]);
    endtask

    task automatic fill_rec(input logic [7:0] mark, input int used);
        rec[0] = mark;
        for (int i = 1; i < NB; i++) rec[i] = (i <= used) ? 8'($urandom) : 8'h00;
    endtask

    task automatic write_rec(input string req, input logic with_strobe);
        logic [15:0] got;
        do_preset(1'b1, with_strobe);
        send_body();
        for (int k = 15; k >= 0; k--) begin
            idle_gap();
            got[k] = ser_o;
            bit_vld_i = 1'b1;
            bit_i = 1'($urandom);
            @(negedge clk);
            bit_vld_i = 1'b0;
        end
        check({req, " R2 R3 R4 emitted check"}, 32'(got), 32'(rec_crc()));
        check({req, " R9 write err"}, 32'(err_o), 32'd0);
    endtask

    task automatic read_rec(input string req, input logic [15:0] flip_chk, input int flip_bit);
        logic [15:0] c = rec_crc() ^ flip_chk;
        do_preset(1'b0, 1'b0);
        for (int i = 0; i < NB; i++)
            for (int k = 7; k >= 0; k--)
                send_bit(rec[i][k] ^ ((i * 8 + 7 - k) == flip_bit));
        for (int k = 15; k >= 1; k--) send_bit(c[k]);
        check({req, " R5 err before last"}, 32'(err_o), 32'd0);
        send_bit(c[0]);
        check({req, " R5 residue"}, 32'(err_o),
              32'((flip_chk != 16'h0) || (flip_bit >= 0)));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset ser_o", 32'(ser_o), 32'd1);
        check("R1 reset err_o", 32'(err_o), 32'd0);

        // write, full random field
        fill_rec(8'hFB, NB - 1);
        write_rec("wr full", 1'b0);
        check("R4 register empty", 32'(ser_o), 32'd0);
        for (int k = 0; k < 16; k++) send_bit(1'b1);
        check("R6 write done ignores strobes", 32'(ser_o), 32'd0);

        // read, correct check bytes
        read_rec("rd clean", 16'h0000, -1);
        // read, one check bit flipped, then extra strobes
        read_rec("rd bad chk", 16'h0001 << $urandom_range(15, 0), -1);
        for (int k = 0; k < 20; k++) send_bit(1'($urandom));
        check("R6 err held", 32'(err_o), 32'd1);
        // read, one body bit flipped
        read_rec("rd bad body", 16'h0000, int'($urandom_range(NB * 8 - 1, 0)));

        // R7 preset coincides with a strobe
        fill_rec(8'hFB, NB - 1);
        write_rec("R7 preset+strobe", 1'b1);

        // short zero-filled field, deleted mark, back-to-back strobes
        max_idle = 0;
        fill_rec(8'hF8, 17);
        write_rec("short F8", 1'b0);
        read_rec("short F8 rd", 16'h0000, -1);

        // R8 idle noise after preset
        max_idle = 1;
        do_preset(1'b1, 1'b0);
        for (int k = 0; k < 30; k++) begin
            bit_i = 1'($urandom);
            @(negedge clk);
        end
        check("R8 idle no change", 32'(ser_o), 32'd1);

        // R1 abort mid-record, then clean record
        for (int k = 0; k < 40; k++) send_bit(1'($urandom));
        fill_rec(8'hFB, NB - 1);
        max_idle = 4;
        write_rec("R1 after abort", 1'b0);

        // random records
        for (int r = 0; r < 4; r++) begin
            max_idle = int'($urandom_range(2, 0));
            fill_rec(($urandom_range(1, 0) != 0) ? 8'hFB : 8'hF8, int'($urandom_range(NB - 1, 1)));
            if ($urandom_range(1, 0) != 0) write_rec("rand wr", 1'b0);
            else read_rec("rand rd", 16'h0000, ($urandom_range(1, 0) != 0) ? 5 : -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule